// File: doc/BRIEF.md
# Bipolar Line Decoder with Violation Flag

This block sits behind a line receiver that has already sliced the bipolar signal into two rail bits, one bit per clock. It removes the zero-substitution codes that a transmitter inserts into long runs of spaces and returns the original mark stream on two decoded rails. It also produces a binary NRZ output and a one-bit violation flag. A mode input selects the short substitution rule or the long one. The short rule replaces runs of three spaces and the long rule replaces runs of four. A disable input turns decoding off, so the rails pass straight through on a shorter path. A loopback input takes the rails from the local encoder instead of the line.

A violation is a single mark with the same polarity as the previous single mark. A violation that is part of a legal substitution is removed from the data, together with its balancing pulse. Any other violation stays in the data and raises the flag. A mark on both rails in the same bit also raises the flag. The flag stays aligned with the output bit that caused it. The interface runs at a fixed rate of one bit per clock. Nothing can be stalled, so there is no handshake.

Top module: `bipolar_line_decoder`

## Requirements
- R1: With `mode_b3`=1, a single mark that repeats the previous mark's polarity after one or more spaces is a legal substitution pulse. It is removed from the output. If the bit two places before it is a single mark, that mark is removed as well. No flag is raised.
- R2: With `mode_b3`=0, a repeated-polarity single mark is legal only after at least two spaces. It is removed from the output. If the bit three places before it is a single mark, that mark is removed as well. No flag is raised.
- R3: With `dec_off`=0, a bit presented before rising edge k appears on the outputs right after rising edge k+6 (parameter `DEC_LAT`).
- R4: With `dec_off`=1, the outputs copy the selected rails with a latency of 2 edges, and nothing is removed.
- R5: With `dec_off`=0, a repeated-polarity mark with too few spaces before it stays in the output and has `viol` high. Too few means none in the short mode and fewer than two in the long mode.
- R6: With `dec_off`=1, every repeated-polarity single mark raises `viol`.
- R7: A bit with both rails high appears with both outputs high and `viol` high. It does not change the polarity reference.
- R8: `viol` is high only in the output bit of the offending mark, for that one bit period.
- R9: `out_nrz` equals `out_p` OR `out_n` in every cycle.
- R10: With `loop_en`=1 the decoder takes `loop_p`/`loop_n` and ignores the line rails. With `loop_en`=0 it takes `line_p`/`line_n` and ignores the loop rails.
- R11: After reset all outputs are low. The first single mark after reset is never treated as a repeated polarity. On the rails, p alone is a positive mark and n alone is a negative mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_b3 | input | 1 | 1: three-space substitution rule, 0: four-space rule |
| dec_off | input | 1 | 1: bypass decoding, flag every repeated polarity |
| loop_en | input | 1 | 1: take rails from the local encoder |
| line_p | input | 1 | Positive rail from the line receiver |
| line_n | input | 1 | Negative rail from the line receiver |
| loop_p | input | 1 | Positive rail from the local encoder |
| loop_n | input | 1 | Negative rail from the local encoder |
| out_p | output | 1 | Decoded positive rail |
| out_n | output | 1 | Decoded negative rail |
| out_nrz | output | 1 | OR of the decoded rails |
| viol | output | 1 | Violation or coding-error flag, aligned with its bit |

## Verification
The hardest cases to reach are illegal violations and double marks, because a correct encoder never emits them. The bench therefore loads hand-built rail sequences alongside the random encoder round trips. Some of these sequences are fed in both modes. For example, a mark, one space and a repeated-polarity mark decode as a legal substitution in the short mode and as a flagged error in the long mode. Other sequences start with a mark immediately after reset, which tests the missing polarity history.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // one bit slot travelling through the decoder
  typedef struct packed {
    logic p;
    logic n;
    logic flg;
  } lc_sym_t;

  // register stages on the bypass path
  localparam int unsigned LC_BYP_LAT = 2;
  // raw bit history kept for legality decisions
  localparam int unsigned LC_HIST = 3;
endpackage

// File: rtl/lc_rail_sel.sv
module lc_rail_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic line_p,
  input  logic line_n,
  input  logic loop_p,
  input  logic loop_n,
  output logic cap_p,
  output logic cap_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_p <= 1'b0;
      cap_n <= 1'b0;
    end else begin
      cap_p <= loop_en ? loop_p : line_p;
      cap_n <= loop_en ? loop_n : line_n;
    end
  end
endmodule

// File: rtl/lc_viol_class.sv
module lc_viol_class
  import lc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mode_b3,
  input  logic    cur_p,
  input  logic    cur_n,
  output lc_sym_t ent,
  output logic    flag_raw,
  output logic    clr_b2,
  output logic    clr_b3
);
  logic                cur_one, cur_two, is_v, legal;
  logic                seen_q, lastn_q;
  logic [LC_HIST-1:0]  h_any, h_one;   // index 0 is the previous bit

  always_comb begin
    cur_one  = cur_p ^ cur_n;
    cur_two  = cur_p & cur_n;
    is_v     = cur_one & seen_q & (cur_n == lastn_q);
    if (mode_b3) legal = is_v & ~h_any[0];
    else         legal = is_v & ~h_any[0] & ~h_any[1];
    clr_b2   = mode_b3  & legal & h_one[1];
    clr_b3   = ~mode_b3 & legal & h_one[2];
    flag_raw = is_v | cur_two;
    if (legal) ent = '0;
    else       ent = '{p: cur_p, n: cur_n, flg: flag_raw};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      lastn_q <= 1'b0;
      h_any   <= '0;
      h_one   <= '0;
    end else begin
      if (cur_one) begin
        seen_q  <= 1'b1;
        lastn_q <= cur_n;
      end
      h_any <= {h_any[LC_HIST-2:0], cur_p | cur_n};
      h_one <= {h_one[LC_HIST-2:0], cur_one};
    end
  end
endmodule

// File: rtl/lc_strip_pipe.sv
module lc_strip_pipe
  import lc_pkg::*;
#(
  parameter int unsigned DEPTH = 6   // at least 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  lc_sym_t ent,
  input  logic    clr_b2,
  input  logic    clr_b3,
  output lc_sym_t tail
);
  lc_sym_t win [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) win[0] <= '0;
    else        win[0] <= ent;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    localparam bit IS_B2 = (g == 2);
    localparam bit IS_B3 = (g == 3);
    always_ff @(posedge clk) begin
      if (!rst_n)                                    win[g] <= '0;
      else if ((IS_B2 && clr_b2) || (IS_B3 && clr_b3)) win[g] <= '0;
      else                                           win[g] <= win[g-1];
    end
  end

  assign tail = win[DEPTH-1];
endmodule

// File: rtl/bipolar_line_decoder.sv
module bipolar_line_decoder
  import lc_pkg::*;
#(
  parameter int unsigned DEC_LAT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_b3,
  input  logic dec_off,
  input  logic loop_en,
  input  logic line_p,
  input  logic line_n,
  input  logic loop_p,
  input  logic loop_n,
  output logic out_p,
  output logic out_n,
  output logic out_nrz,
  output logic viol
);
  logic    cap_p, cap_n, flag_raw, clr_b2, clr_b3;
  lc_sym_t ent, dec_tail, out_sym;
  lc_sym_t byp [LC_BYP_LAT];

  lc_rail_sel u_sel (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
    .line_p(line_p), .line_n(line_n), .loop_p(loop_p), .loop_n(loop_n),
    .cap_p(cap_p), .cap_n(cap_n)
  );

  lc_viol_class u_cls (
    .clk(clk), .rst_n(rst_n), .mode_b3(mode_b3),
    .cur_p(cap_p), .cur_n(cap_n),
    .ent(ent), .flag_raw(flag_raw), .clr_b2(clr_b2), .clr_b3(clr_b3)
  );

  lc_strip_pipe #(.DEPTH(DEC_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .ent(ent),
    .clr_b2(clr_b2), .clr_b3(clr_b3), .tail(dec_tail)
  );

  // short path used when decoding is off
  always_ff @(posedge clk) begin
    if (!rst_n) byp[0] <= '0;
    else        byp[0] <= '{p: cap_p, n: cap_n, flg: flag_raw};
  end
  for (genvar g = 1; g < LC_BYP_LAT; g++) begin : g_byp
    always_ff @(posedge clk) begin
      if (!rst_n) byp[g] <= '0;
      else        byp[g] <= byp[g-1];
    end
  end

  always_comb begin
    out_sym = dec_off ? byp[LC_BYP_LAT-1] : dec_tail;
    out_p   = out_sym.p;
    out_n   = out_sym.n;
    viol    = out_sym.flg;
    out_nrz = out_sym.p | out_sym.n;
  end

  // R7: a double mark always leaves with the flag set
  p_dbl_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_p && out_n) |-> viol);

  // R8: the flag only ever sits on a mark
  p_flag_on_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (out_p || out_n));

  // R4: bypass output is the captured rail pair two edges later
  p_bypass_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_off |-> (out_p == $past(cap_p, 2)) && (out_n == $past(cap_n, 2)));

  // R5: adjacent same-polarity marks in decoded output are always flagged
  p_adjacent_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_off && !$past(dec_off) && (out_p ^ out_n) &&
     ($past(out_p) ^ $past(out_n)) && (out_n == $past(out_n))) |-> viol);
endmodule

// File: tb/sim_bipolar_line_decoder.sv
module sim_bipolar_line_decoder;
  localparam int MAXN = 600;
  localparam int DLAT = 6;
  localparam int BLAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, mode_b3 = 1'b1, dec_off = 1'b0, loop_en = 1'b0;
  logic line_p = 1'b0, line_n = 1'b0, loop_p = 1'b0, loop_n = 1'b0;
  logic out_p, out_n, out_nrz, viol;

  bipolar_line_decoder #(.DEC_LAT(DLAT)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_b3(mode_b3), .dec_off(dec_off),
    .loop_en(loop_en), .line_p(line_p), .line_n(line_n),
    .loop_p(loop_p), .loop_n(loop_n),
    .out_p(out_p), .out_n(out_n), .out_nrz(out_nrz), .viol(viol)
  );

  logic [1:0] stim [MAXN];
  logic [1:0] garb [MAXN];
  logic [2:0] expv [MAXN];
  int nlen;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp, int idx);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s bit %0d actual=%b expected=%b", req, idx, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < MAXN; i++) begin
      stim[i] = 2'b00;
      expv[i] = 3'b000;
      garb[i] = 2'($urandom);
    end
  endtask

  function automatic logic [1:0] sym_of(byte ch);
    case (ch)
      "+": return 2'b10;
      "-": return 2'b01;
      "*": return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [2:0] exp_of(byte ch);
    case (ch)
      "+": return 3'b100;
      "-": return 3'b010;
      "P": return 3'b101;
      "N": return 3'b011;
      "X": return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  task automatic load(string s, string e);
    clear_all();
    nlen = s.len();
    for (int i = 0; i < nlen; i++) begin
      stim[i] = sym_of(s[i]);
      expv[i] = exp_of(e[i]);
    end
  endtask

  // expected outputs with decoding off: copy rails, flag repeats and doubles
  task automatic raw_expect();
    bit seen = 0;
    bit lastn = 0;
    for (int i = 0; i < nlen; i++) begin
      logic [1:0] s = stim[i];
      bit f = 0;
      if (s == 2'b11) f = 1;
      else if (s != 2'b00) begin
        if (seen && (s[0] == lastn)) f = 1;
        seen = 1;
        lastn = s[0];
      end
      expv[i] = {s, f};
    end
  endtask

  // reference encoder: random data, substitution by the selected rule
  task automatic enc_fill(int n, bit mb3, int dens);
    bit d [MAXN];
    int z = mb3 ? 3 : 4;
    bit lastn = 1;
    int nb = 0;
    int i = 0;
    clear_all();
    nlen = n;
    for (int k = 0; k < n; k++) d[k] = (($urandom % 100) < dens);
    while (i < n) begin
      if (d[i]) begin
        bit pol = !lastn;
        stim[i] = pol ? 2'b01 : 2'b10;
        expv[i] = {~pol, pol, 1'b0};
        lastn = pol; nb++; i++;
      end else begin
        bit run = (i + z <= n);
        for (int k = 0; k < z; k++) if (run && d[i+k]) run = 0;
        if (run) begin
          if (nb % 2 == 1) begin
            stim[i+z-1] = lastn ? 2'b01 : 2'b10;
          end else begin
            bit b = !lastn;
            stim[i]     = b ? 2'b01 : 2'b10;
            stim[i+z-1] = b ? 2'b01 : 2'b10;
            lastn = b;
          end
          nb = 0;
          i += z;
        end else begin
          i++;
        end
      end
    end
  endtask

  task automatic run(string req, bit mb3, bit off, bit lp);
    int lat = off ? BLAT : DLAT;
    @(negedge clk);
    rst_n = 0; mode_b3 = mb3; dec_off = off; loop_en = lp;
    line_p = 0; line_n = 0; loop_p = 0; loop_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R11 reset", {out_p, out_n, viol}, 3'b000, -1);
    for (int c = 0; c <= nlen + lat; c++) begin
      int b = c - lat - 1;
      logic [1:0] s, g;
      @(negedge clk);
      if (b >= 0 && b < nlen) begin
        chk(req, {out_p, out_n, viol}, expv[b], b);
        chk("R9 nrz", {2'b00, out_nrz}, {2'b00, expv[b][2] | expv[b][1]}, b);
      end
      s = (c < nlen) ? stim[c] : 2'b00;
      g = (c < MAXN) ? garb[c] : 2'b00;
      {line_p, line_n} = lp ? g : s;
      {loop_p, loop_n} = lp ? s : g;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // directed: R1 legal short-rule substitutions stripped
    load("-+0+00", "-00000");  run("R1 B0V strip R8", 1, 0, 0);
    load("+00+0",  "+0000");   run("R1 00V strip", 1, 0, 0);
    // directed: R2 long rule, same first stream is now an error (R5)
    load("-+0+00", "-+0P00");  run("R5 long-rule short gap R2", 0, 0, 0);
    load("+-00-0", "+00000");  run("R2 B00V strip", 0, 0, 0);
    load("+000+0", "+00000");  run("R2 000V strip", 0, 0, 0);
    // directed: R5 illegal violations kept and flagged once (R8)
    load("+-++00-", "+-+P00-"); run("R5 adjacent repeat R8", 1, 0, 0);
    load("+0+00-",  "+0P00-");  run("R5 long-rule one gap R8", 0, 0, 0);
    // directed: R7 double mark in both modes
    load("+*-0", "+X-0"); run("R7 double short", 1, 0, 0);
    load("+*-0", "+X-0"); run("R7 double long", 0, 0, 0);
    // directed: R4 and R6 with decoding off
    load("-+0+*0--", "-+0PX0-N"); run("R6 bypass flags R4", 1, 1, 0);
    load("-+0+00",   "-+0P00");   run("R4 no strip when off R6", 1, 1, 0);
    // directed: R11 first mark after reset is positive, not a repeat
    load("+0-", "+0-"); run("R11 first mark", 1, 1, 0);
    load("+0-", "+0-"); run("R11 first mark dec", 0, 0, 0);

    // random round trips through the reference encoder (R1 R2 R3)
    enc_fill(400, 1, 30); run("R1 R3 random short", 1, 0, 0);
    enc_fill(400, 1, 60); run("R1 R3 random short dense", 1, 0, 0);
    enc_fill(400, 0, 30); run("R2 R3 random long", 0, 0, 0);
    enc_fill(400, 0, 55); run("R2 R3 random long dense", 0, 0, 0);
    // R10 loopback: encoder stream on loop rails, noise on line rails
    enc_fill(300, 0, 45); run("R10 loopback long", 0, 0, 1);
    enc_fill(300, 1, 45); run("R10 loopback short", 1, 0, 1);

    // random raw symbols with decoding off (R4 R6 R7)
    clear_all();
    nlen = 300;
    for (int i = 0; i < nlen; i++) begin
      int r = int'($urandom % 10);
      stim[i] = (r < 5) ? 2'b00 : (r < 7) ? 2'b10 : (r < 9) ? 2'b01 : 2'b11;
    end
    raw_expect();
    run("R6 R4 R7 random bypass", 0, 1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule